// File: doc/BRIEF.md
# Asynchronous serial transceiver with run-time parity selection

This block is a full-duplex asynchronous serial port. The transmit half takes one byte at a time through a valid/ready handshake. It shifts out a start bit, the eight data bits least-significant first, an optional parity bit and a stop bit. The receive half watches the incoming line at sixteen times the bit rate. It rebuilds the byte and presents it on a single-cycle strobe, together with a parity-error flag and a framing-error flag.

A two-bit input selects one of four parity behaviours: even, odd, a slot that is always transmitted as zero and never checked, or no parity slot at all. Both halves latch this selection when a frame begins, so a change made mid-frame only affects later frames. A divisor input sets the oversampling tick rate, and with it the bit rate. The reset input is asynchronous and active low, and it is released synchronously inside the block.

Top module: `uart_par_top`

## Requirements
- R1: The transmit line is 1 while idle. A frame is a 0 start bit, eight data bits with bit 0 first, the optional parity slot, and a 1 stop bit. Each bit lasts 16 oversampling ticks.
- R2: With mode code 2'b11 (even), the transmitted parity slot holds the XOR of the data bits, which makes the total count of ones even.
- R3: With mode code 2'b10 (odd), the transmitted parity slot holds the inverted XOR of the data bits, which makes the total count of ones odd.
- R4: With mode code 2'b01 (zero slot), the transmitted parity slot is always 0, whatever the data.
- R5: With mode code 2'b00 (none), no parity slot is sent. The stop bit directly follows data bit 7, so a frame is 10 bits long.
- R6: In even mode the receiver raises the parity error when the received data bits plus the parity bit contain an odd number of ones.
- R7: In odd mode the receiver raises the parity error when the received data bits plus the parity bit contain an even number of ones.
- R8: In zero-slot mode the received parity slot is ignored. In none mode the receiver expects the stop bit right after bit 7. In both modes the parity error is never raised.
- R9: The framing error is raised when the stop bit is sampled as 0. Both error flags are presented with the received byte during a single-cycle valid pulse.
- R10: `tx_ready` is high only while the transmitter is idle. It goes low on the cycle after a handshake is accepted and stays low until the stop bit has been sent in full.
- R11: The parity mode is captured at the start of each frame. Changing `par_mode` during a frame does not alter that frame on either side.
- R12: The oversampling tick fires once every `baud_div`+1 clock cycles. The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge, so a shorter low pulse produces no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Tick period minus one, in clock cycles |
| par_mode | input | 2 | Parity mode: 00 none, 01 zero slot, 10 odd, 11 even |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_line | output | 1 | Serial transmit line |
| rx_line | input | 1 | Serial receive line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe marking a received frame |
| rx_par_err | output | 1 | Parity error of the frame marked by rx_valid |
| rx_frm_err | output | 1 | Framing error of the frame marked by rx_valid |

## Verification
The two receive checks, the parity test and the stop-bit test, both complete in the single cycle where the valid pulse is raised. A frame that is wrong in both respects must therefore set both flags in the same pulse. The bench injects frames on the receive line with a deliberately wrong parity bit and a stop bit of 0, and it also randomises parity bits and stop values. For each frame it predicts both flags independently from the mode, the data and the bits it drove, and it compares both against the single pulse.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } frame_st_e;

  // Parity bit to send, given the XOR of the data bits.
  function automatic logic par_bit(input logic data_xor, input par_mode_e mode);
    case (mode)
      PAR_EVEN: par_bit = data_xor;
      PAR_ODD:  par_bit = ~data_xor;
      default:  par_bit = 1'b0;
    endcase
  endfunction

  // Error verdict, given the XOR of the data bits and the received parity bit.
  function automatic logic par_fail(input logic total_xor, input par_mode_e mode);
    case (mode)
      PAR_EVEN: par_fail = total_xor;
      PAR_ODD:  par_fail = ~total_xor;
      default:  par_fail = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_par_baud.sv
module uart_par_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    if (cnt_q >= div_i) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R12: a tick is followed by a gap whenever the divisor is non-zero
  a_r12_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && div_i != '0) |=> !tick_q);

endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_par_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  par_mode_e         mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  frame_st_e         st_q, st_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  par_mode_e         mode_q, mode_d;
  logic              line_q, line_d;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    mode_d = mode_q;
    line_d = line_q;
    if (st_q == ST_IDLE) begin
      line_d = 1'b1;
      if (valid_i) begin
        sh_d   = data_i;
        par_d  = par_bit(^data_i, mode_i);
        mode_d = mode_i;
        tcnt_d = '0;
        idx_d  = '0;
        st_d   = ST_START;
        line_d = 1'b0;
      end
    end else if (tick_i) begin
      tcnt_d = tcnt_q + 1'b1;
      if (tcnt_q == CNT_LAST) begin
        tcnt_d = '0;
        case (st_q)
          ST_START: begin
            st_d   = ST_DATA;
            line_d = sh_q[0];
          end
          ST_DATA: begin
            if (idx_q == IDX_LAST) begin
              if (mode_q == PAR_NONE) begin
                st_d   = ST_STOP;
                line_d = 1'b1;
              end else begin
                st_d   = ST_PAR;
                line_d = par_q;
              end
            end else begin
              idx_d  = idx_q + 1'b1;
              sh_d   = sh_q >> 1;
              line_d = sh_q[1];
            end
          end
          ST_PAR: begin
            st_d   = ST_STOP;
            line_d = 1'b1;
          end
          default: begin
            st_d   = ST_IDLE;
            line_d = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      mode_q <= PAR_NONE;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      mode_q <= mode_d;
      line_q <= line_d;
    end
  end

  assign ready_o = (st_q == ST_IDLE);
  assign line_o  = line_q;

  // R10: an accepted request makes the transmitter busy
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !ready_o);
  // R1: the start bit goes out right after acceptance
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !line_o);
  // R1: the line is high whenever the transmitter is idle
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> line_o);
  // R11: the captured mode does not move while a frame is in flight
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && $past(!ready_o)) |-> $stable(mode_q));

endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx
  import uart_par_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  par_mode_e         mode_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic              s1_q, s2_q;
  logic              seen_q, seen_d;
  frame_st_e         st_q, st_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  par_mode_e         mode_q, mode_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;

  always_comb begin
    seen_d  = tick_i ? s2_q : seen_q;
    st_d    = st_q;
    tcnt_d  = tcnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    mode_d  = mode_q;
    data_d  = data_q;
    valid_d = 1'b0;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    if (tick_i) begin
      tcnt_d = tcnt_q + 1'b1;
      case (st_q)
        ST_IDLE: begin
          tcnt_d = '0;
          if (seen_q && !s2_q) begin
            st_d   = ST_START;
            mode_d = mode_i;
          end
        end
        ST_START: begin
          if (tcnt_q == CNT_MID) begin
            tcnt_d = '0;
            idx_d  = '0;
            st_d   = s2_q ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (tcnt_q == CNT_LAST) begin
            sh_d = {s2_q, sh_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) begin
              st_d = (mode_q == PAR_NONE) ? ST_STOP : ST_PAR;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tcnt_q == CNT_LAST) begin
            pbit_d = s2_q;
            st_d   = ST_STOP;
          end
        end
        default: begin
          if (tcnt_q == CNT_LAST) begin
            valid_d = 1'b1;
            data_d  = sh_q;
            ferr_d  = !s2_q;
            perr_d  = par_fail((^sh_q) ^ pbit_q, mode_q);
            st_d    = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      seen_q  <= 1'b0;
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      mode_q  <= PAR_NONE;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      s1_q    <= line_i;
      s2_q    <= s1_q;
      seen_q  <= seen_d;
      st_q    <= st_d;
      tcnt_q  <= tcnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      mode_q  <= mode_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;

  // R9: the valid strobe lasts exactly one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R8: modes without a checked parity slot never report a parity error
  a_r8_quiet_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (mode_q == PAR_NONE || mode_q == PAR_ZERO)) |-> !par_err_o);
  // R11: the captured mode stays put until the receiver is idle again
  a_r11_rx_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q != ST_IDLE)) |-> $stable(mode_q));

endmodule

// File: rtl/uart_par_top.sv
module uart_par_top
  import uart_par_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       par_mode,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_line,
  input  logic             rx_line,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_par_err,
  output logic             rx_frm_err
);

  localparam int DATA_W = 8;
  localparam int OSR    = 16;

  logic rs1_q, rs2_q;
  logic rst_int_n;
  logic tick;
  par_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign rst_int_n = rs2_q;
  assign mode      = par_mode_e'(par_mode);

  uart_par_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .div_i  (baud_div),
    .tick_o (tick)
  );

  uart_par_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (tick),
    .mode_i  (mode),
    .data_i  (tx_data),
    .valid_i (tx_valid),
    .ready_o (tx_ready),
    .line_o  (tx_line)
  );

  uart_par_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick),
    .mode_i    (mode),
    .line_i    (rx_line),
    .data_o    (rx_data),
    .valid_o   (rx_valid),
    .par_err_o (rx_par_err),
    .frm_err_o (rx_frm_err)
  );

endmodule

// File: tb/uart_par_top_tb.sv
module uart_par_top_tb_top;

  localparam int DIV  = 3;
  localparam int BITC = 16 * (DIV + 1);

  logic        clk;
  logic        rst_n;
  logic [15:0] baud_div;
  logic [1:0]  par_mode;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic        tx_line;
  logic        rx_line;
  logic        rx_drv;
  logic        loop_en;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_par_err;
  logic        rx_frm_err;

  int checks = 0;
  int fails  = 0;
  int got_cnt = 0;
  logic [7:0] got_data;
  logic       got_perr;
  logic       got_ferr;

  assign rx_line = loop_en ? tx_line : rx_drv;

  uart_par_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_div   (baud_div),
    .par_mode   (par_mode),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_line    (tx_line),
    .rx_line    (rx_line),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rx_valid) begin
      got_cnt  <= got_cnt + 1;
      got_data <= rx_data;
      got_perr <= rx_par_err;
      got_ferr <= rx_frm_err;
    end
  end

  function automatic logic exp_pbit(input logic [7:0] d, input logic [1:0] m);
    case (m)
      2'b11:   return ^d;
      2'b10:   return ~^d;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_perr(input logic [7:0] d, input logic p, input logic [1:0] m);
    case (m)
      2'b11:   return (^d) ^ p;
      2'b10:   return ~((^d) ^ p);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Loopback frame: check the wire bits, the ready timing and the received byte.
  task automatic tx_frame(input logic [7:0] d, input logic [1:0] m, input bit flip_mode);
    logic [7:0] bits;
    logic pb;
    int c0;
    string ptag;
    loop_en  = 1'b1;
    par_mode = m;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    c0 = got_cnt;
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R10 ready low after accept", tx_ready, 0);
    repeat (BITC / 2 - 1) @(negedge clk);
    chk(tx_line == 1'b0, "R1 start bit", tx_line, 0);
    if (flip_mode) par_mode = ~m;
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      bits[i] = tx_line;
    end
    chk(bits == d, "R1 data bits lsb first", bits, d);
    if (m != 2'b00) begin
      repeat (BITC) @(negedge clk);
      pb = tx_line;
      ptag = (m == 2'b11) ? "R2 even parity slot" :
             (m == 2'b10) ? "R3 odd parity slot" : "R4 zero parity slot";
      if (flip_mode) ptag = "R11 mode held during frame";
      chk(pb == exp_pbit(d, m), ptag, pb, exp_pbit(d, m));
    end
    repeat (BITC) @(negedge clk);
    chk(tx_line == 1'b1, (m == 2'b00) ? "R5 stop follows bit 7" : "R1 stop bit", tx_line, 1);
    chk(tx_ready == 1'b0, "R10 busy during stop", tx_ready, 0);
    repeat (BITC) @(negedge clk);
    chk(tx_ready == 1'b1, (m == 2'b00) ? "R5 ten-bit frame" : "R10 ready after stop", tx_ready, 1);
    chk(got_cnt == c0 + 1, "R9 one byte received", got_cnt - c0, 1);
    chk(got_data == d, "R1 loopback data", got_data, d);
    chk(got_perr == 1'b0, flip_mode ? "R11 rx mode held" : "R6 R7 R8 clean parity", got_perr, 0);
    chk(got_ferr == 1'b0, "R9 no framing error", got_ferr, 0);
    par_mode = m;
  endtask

  // Frame driven straight onto the receive line.
  task automatic rx_inject(input logic [7:0] d, input logic p, input logic stopb, input logic [1:0] m, input string tag);
    int c0;
    logic ep;
    loop_en  = 1'b0;
    par_mode = m;
    c0 = got_cnt;
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = d[i];
      repeat (BITC) @(negedge clk);
    end
    if (m != 2'b00) begin
      rx_drv = p;
      repeat (BITC) @(negedge clk);
    end
    rx_drv = stopb;
    repeat (BITC) @(negedge clk);
    rx_drv = 1'b1;
    repeat (BITC) @(negedge clk);
    ep = (m == 2'b00) ? 1'b0 : exp_perr(d, p, m);
    chk(got_cnt == c0 + 1, {tag, " R9 strobe count"}, got_cnt - c0, 1);
    chk(got_data == d, {tag, " R9 data"}, got_data, d);
    chk(got_perr == ep, {tag, " parity flag"}, got_perr, ep);
    chk(got_ferr == !stopb, {tag, " R9 framing flag"}, got_ferr, !stopb);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [1:0] m;
    logic p, s;
    int c0;
    void'($urandom(32'h1357_2468));
    rst_n    = 1'b0;
    baud_div = 16'(DIV);
    par_mode = 2'b11;
    tx_data  = 8'h00;
    tx_valid = 1'b0;
    rx_drv   = 1'b1;
    loop_en  = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b1, "R1 idle line in reset", tx_line, 1);
    chk(rx_valid == 1'b0, "R9 no strobe in reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_ready == 1'b1, "R10 ready after reset", tx_ready, 1);
    chk(tx_line == 1'b1, "R1 idle line after reset", tx_line, 1);

    // directed transmit corners
    tx_frame(8'h00, 2'b11, 1'b0);
    tx_frame(8'h01, 2'b11, 1'b0);
    tx_frame(8'hFF, 2'b10, 1'b0);
    tx_frame(8'h07, 2'b10, 1'b0);
    tx_frame(8'hFF, 2'b01, 1'b0);
    tx_frame(8'hA5, 2'b00, 1'b0);
    tx_frame(8'h3C, 2'b11, 1'b1);
    tx_frame(8'h80, 2'b10, 1'b1);

    // directed receive corners
    rx_inject(8'h01, 1'b0, 1'b1, 2'b11, "R6 even bad parity");
    rx_inject(8'h03, 1'b0, 1'b1, 2'b11, "R6 even good parity");
    rx_inject(8'h03, 1'b0, 1'b1, 2'b10, "R7 odd bad parity");
    rx_inject(8'h01, 1'b0, 1'b1, 2'b10, "R7 odd good parity");
    rx_inject(8'h5A, 1'b1, 1'b1, 2'b01, "R8 zero slot sent as 1");
    rx_inject(8'hC3, 1'b0, 1'b1, 2'b00, "R8 no parity slot");
    rx_inject(8'h81, 1'b0, 1'b0, 2'b00, "R9 bad stop no parity");
    rx_inject(8'h10, 1'b0, 1'b0, 2'b11, "R9 both errors one pulse");

    // R12: a low pulse shorter than half a bit is not a start bit
    loop_en = 1'b0;
    c0 = got_cnt;
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk(got_cnt == c0, "R12 short glitch ignored", got_cnt - c0, 0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      d = 8'($urandom);
      m = 2'($urandom);
      tx_frame(d, m, ($urandom % 5) == 0);
    end
    for (int k = 0; k < 30; k++) begin
      d = 8'($urandom);
      m = 2'($urandom);
      p = 1'($urandom);
      s = ($urandom % 4) != 0;
      rx_inject(d, p, s, m, (m == 2'b11) ? "R6 random" : (m == 2'b10) ? "R7 random" : "R8 random");
    end

    finish_run();
  end

endmodule